// File: doc/BRIEF.md
# Windowed Register Aperture Remapper

This block sits behind a host-visible 1 MB register aperture and gives it reach into a 32 MB internal address space. Host requests arrive on a simple single-beat memory-mapped slave port carrying a 20-bit byte offset, a write flag and 32-bit write data. The block turns each one into at most one transaction on a 25-bit internal memory bus, and it returns exactly one registered response per request.

The aperture is split in two halves. Offsets in the lower 512 KB reach the same internal addresses directly. The upper 512 KB is a movable page. The page is picked by a 6-bit page number, and an enable flag lets it be used at all. Both live in a page-control register inside the fixed half of the aperture. Software writes that register and reads it back to confirm the page before it touches the paged half. The block refuses to forward a paged access while the page is disabled, and it refuses any access that is not word aligned. Both cases complete with an error response.

Top module: `bar_window_remap`

## Requirements
- R1: After reset the page number is 0 and the page enable is clear. A read of the page-control register returns 0, and no response is signalled until a request has been made.
- R2: An aligned request whose offset is below 0x80000, and is not the page-control offset, is forwarded in the same cycle. The internal address is the offset zero-extended to 25 bits, the write flag and write data are passed unchanged, and the response has the error flag low.
- R3: An aligned request whose offset is 0x80000 or above is forwarded while the page enable is set. The internal address is the page number in bits 24:19 and offset bits 18:0 below it.
- R4: The page-control register sits at aperture offset 0x310C and is never forwarded. A write stores write-data bit 30 (parameter EN_BIT) as the enable and bits 5:0 as the page number. A read returns the enable in bit EN_BIT and the page number in bits 5:0, with all other bits zero. Bit 31 is ignored while EN_BIT is 30.
- R5: A request to the upper half while the page enable is clear is not forwarded. Its response has the error flag set and read data 0xDEADBEEF.
- R6: A request whose offset bits 1:0 are not zero is not forwarded, even at 0x310D. Its response has the error flag set and read data 0xDEADBEEF.
- R7: Every request produces exactly one response, in the following cycle, and there is no response in a cycle after an idle one. A forwarded read returns the internal bus read data of that response cycle. A write that completes without error returns read data 0.
- R8: A write to the page-control register takes effect for the very next request, including one in the immediately following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Request strobe, one request per cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 20 | Aperture byte offset |
| host_wdata | input | 32 | Write data |
| host_rsp_valid | output | 1 | Response strobe, one cycle after the request |
| host_rsp_err | output | 1 | Response carries an error |
| host_rdata | output | 32 | Response read data |
| mem_req | output | 1 | Internal bus request, same cycle as host request |
| mem_we | output | 1 | Internal bus write flag |
| mem_addr | output | 25 | Internal byte address |
| mem_wdata | output | 32 | Internal write data |
| mem_rdata | input | 32 | Internal read data, valid one cycle after a read request |

## Verification
Two functions can meet in one cycle: the registered response to a page-control write, and the translation of the next request, which must already use the page just written. The bench provokes this by issuing a page-control write and, in the very next cycle, a paged read. It then disables the page and follows at once with another paged read. A behavioural reference model runs alongside and is compared with the internal bus outputs every cycle and with the response in the following cycle. The check passes when the first paged read lands on the new page and the second is refused with an error.

// File: rtl/bwr_pkg.sv
package bwr_pkg;
  // Classification of one host request.
  typedef enum logic [2:0] {
    K_IDLE  = 3'd0,
    K_FIXED = 3'd1,
    K_PAGED = 3'd2,
    K_CTRL  = 3'd3,
    K_ERR   = 3'd4
  } req_kind_e;
endpackage

// File: rtl/bwr_decode.sv
module bwr_decode
  import bwr_pkg::*;
#(
  parameter int          AP_AW    = 20,
  parameter int          DW       = 32,
  parameter logic [19:0] CTRL_OFS = 20'h0310C
) (
  input  logic             req,
  input  logic [AP_AW-1:0] addr,
  input  logic             page_en,
  output req_kind_e        kind
);
  localparam int BYTE_LSB = $clog2(DW / 8);

  logic misaligned;
  logic upper;
  logic ctrl_hit;

  assign misaligned = |addr[BYTE_LSB-1:0];
  assign upper      = addr[AP_AW-1];
  assign ctrl_hit   = (addr == CTRL_OFS[AP_AW-1:0]);

  always_comb begin
    if (!req)            kind = K_IDLE;
    else if (misaligned) kind = K_ERR;
    else if (ctrl_hit)   kind = K_CTRL;
    else if (!upper)     kind = K_FIXED;
    else if (page_en)    kind = K_PAGED;
    else                 kind = K_ERR;
  end
endmodule

// File: rtl/bwr_xlate.sv
module bwr_xlate #(
  parameter int AP_AW = 20,
  parameter int PG_W  = 6,
  parameter int IN_AW = 25
) (
  input  logic [AP_AW-1:0] addr,
  input  logic [PG_W-1:0]  page,
  input  logic             use_page,
  output logic [IN_AW-1:0] mem_addr
);
  localparam int OFS_W = AP_AW - 1;

  logic [IN_AW-1:0] flat_addr;
  logic [IN_AW-1:0] paged_addr;

  generate
    if (IN_AW > AP_AW) begin : g_pad
      assign flat_addr = {{(IN_AW - AP_AW){1'b0}}, addr};
    end else begin : g_trunc
      assign flat_addr = addr[IN_AW-1:0];
    end
    if (IN_AW == OFS_W + PG_W) begin : g_exact
      assign paged_addr = {page, addr[OFS_W-1:0]};
    end else begin : g_fit
      logic [OFS_W+PG_W-1:0] wide;
      assign wide       = {page, addr[OFS_W-1:0]};
      assign paged_addr = wide[IN_AW-1:0];
    end
  endgenerate

  assign mem_addr = use_page ? paged_addr : flat_addr;
endmodule

// File: rtl/bwr_pagereg.sv
module bwr_pagereg #(
  parameter int DW     = 32,
  parameter int PG_W   = 6,
  parameter int EN_BIT = 30
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic            wen_bit,
  input  logic [PG_W-1:0] wpage,
  output logic            page_en,
  output logic [PG_W-1:0] page,
  output logic [DW-1:0]   rd_word
);
  always_ff @(posedge clk) begin
    if (rst) begin
      page_en <= 1'b0;
      page    <= '0;
    end else if (wr) begin
      page_en <= wen_bit;
      page    <= wpage;
    end
  end

  always_comb begin
    rd_word                = '0;
    rd_word[EN_BIT]        = page_en;
    rd_word[PG_W-1:0]      = page;
  end

  p_take_write_r4: assert property (@(posedge clk) disable iff (rst)
    wr |=> (page == $past(wpage)) && (page_en == $past(wen_bit)));

  p_hold_idle_r4: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(page) && $stable(page_en));
endmodule

// File: rtl/bwr_resp.sv
module bwr_resp
  import bwr_pkg::*;
#(
  parameter int          DW       = 32,
  parameter logic [31:0] ERR_WORD = 32'hDEADBEEF
) (
  input  logic          clk,
  input  logic          rst,
  input  req_kind_e     kind,
  input  logic          we,
  input  logic [DW-1:0] ctrl_word,
  input  logic [DW-1:0] mem_rdata,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [DW-1:0] rdata
);
  logic          take_mem_q;
  logic [DW-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_err    <= 1'b0;
      take_mem_q <= 1'b0;
      word_q     <= '0;
    end else begin
      rsp_valid  <= (kind != K_IDLE);
      rsp_err    <= (kind == K_ERR);
      take_mem_q <= ((kind == K_FIXED) || (kind == K_PAGED)) && !we;
      if (kind == K_ERR)               word_q <= ERR_WORD[DW-1:0];
      else if (kind == K_CTRL && !we)  word_q <= ctrl_word;
      else                             word_q <= '0;
    end
  end

  assign rdata = take_mem_q ? mem_rdata : word_q;

  p_one_rsp_r7: assert property (@(posedge clk) disable iff (rst)
    (kind != K_IDLE) |=> rsp_valid);

  p_no_rsp_r7: assert property (@(posedge clk) disable iff (rst)
    (kind == K_IDLE) |=> !rsp_valid && !rsp_err);
endmodule

// File: rtl/bar_window_remap.sv
module bar_window_remap
  import bwr_pkg::*;
#(
  parameter int          AP_AW    = 20,
  parameter int          DW       = 32,
  parameter int          PG_W     = 6,
  parameter int          EN_BIT   = 30,
  parameter logic [19:0] CTRL_OFS = 20'h0310C,
  parameter logic [31:0] ERR_WORD = 32'hDEADBEEF,
  parameter int          IN_AW    = AP_AW - 1 + PG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_req,
  input  logic             host_we,
  input  logic [AP_AW-1:0] host_addr,
  input  logic [DW-1:0]    host_wdata,
  output logic             host_rsp_valid,
  output logic             host_rsp_err,
  output logic [DW-1:0]    host_rdata,
  output logic             mem_req,
  output logic             mem_we,
  output logic [IN_AW-1:0] mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata
);
  req_kind_e       kind;
  logic            page_en;
  logic [PG_W-1:0] page;
  logic [DW-1:0]   ctrl_word;
  logic            ctrl_wr;

  bwr_decode #(.AP_AW(AP_AW), .DW(DW), .CTRL_OFS(CTRL_OFS)) u_decode (
    .req     (host_req),
    .addr    (host_addr),
    .page_en (page_en),
    .kind    (kind)
  );

  assign ctrl_wr = (kind == K_CTRL) && host_we;

  bwr_pagereg #(.DW(DW), .PG_W(PG_W), .EN_BIT(EN_BIT)) u_pagereg (
    .clk     (clk),
    .rst     (rst),
    .wr      (ctrl_wr),
    .wen_bit (host_wdata[EN_BIT]),
    .wpage   (host_wdata[PG_W-1:0]),
    .page_en (page_en),
    .page    (page),
    .rd_word (ctrl_word)
  );

  bwr_xlate #(.AP_AW(AP_AW), .PG_W(PG_W), .IN_AW(IN_AW)) u_xlate (
    .addr     (host_addr),
    .page     (page),
    .use_page (kind == K_PAGED),
    .mem_addr (mem_addr)
  );

  assign mem_req   = (kind == K_FIXED) || (kind == K_PAGED);
  assign mem_we    = host_we;
  assign mem_wdata = host_wdata;

  bwr_resp #(.DW(DW), .ERR_WORD(ERR_WORD)) u_resp (
    .clk       (clk),
    .rst       (rst),
    .kind      (kind),
    .we        (host_we),
    .ctrl_word (ctrl_word),
    .mem_rdata (mem_rdata),
    .rsp_valid (host_rsp_valid),
    .rsp_err   (host_rsp_err),
    .rdata     (host_rdata)
  );

  p_paged_off_r5: assert property (@(posedge clk) disable iff (rst)
    (host_req && host_addr[AP_AW-1] && !page_en) |-> !mem_req);

  p_paged_off_err_r5: assert property (@(posedge clk) disable iff (rst)
    (host_req && host_addr[AP_AW-1] && !page_en) |=> host_rsp_err);

  p_misaligned_r6: assert property (@(posedge clk) disable iff (rst)
    (host_req && (host_addr[1:0] != 2'b00)) |=> host_rsp_err && (host_rdata == ERR_WORD[DW-1:0]));

  p_ctrl_local_r4: assert property (@(posedge clk) disable iff (rst)
    (host_req && host_addr == CTRL_OFS[AP_AW-1:0]) |-> !mem_req);

  p_fixed_map_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !host_addr[AP_AW-1]) |-> (mem_addr[AP_AW-1:0] == host_addr) && (mem_addr[IN_AW-1:AP_AW] == '0));
endmodule

// File: tb/bar_window_remap_test.sv
module bar_window_remap_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [19:0] CTRL = 20'h0310C;
  localparam logic [31:0] BAD  = 32'hDEADBEEF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_req = 1'b0;
  logic        host_we = 1'b0;
  logic [19:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic        host_rsp_valid, host_rsp_err;
  logic [31:0] host_rdata;
  logic        mem_req, mem_we;
  logic [24:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;

  int checks = 0;
  int failures = 0;

  // model state
  logic        m_en = 1'b0;
  logic [5:0]  m_pg = '0;
  logic        x_valid = 1'b0, x_err = 1'b0;
  logic [31:0] x_rdata = '0;
  string       x_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  bar_window_remap uut (
    .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rsp_valid(host_rsp_valid), .host_rsp_err(host_rsp_err),
    .host_rdata(host_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // internal memory stand-in: read data one cycle after request
  always @(posedge clk)
    if (mem_req && !mem_we) mem_rdata <= {7'h5A, mem_addr};

  task automatic fail_line(input string tag, input string what,
                           input logic [63:0] act, input logic [63:0] exp);
    failures++;
    $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
  endtask

  task automatic check_rsp();
    checks++;
    if (host_rsp_valid !== x_valid)
      fail_line({"R7/", x_tag}, "rsp_valid", 64'(host_rsp_valid), 64'(x_valid));
    else if (x_valid && host_rsp_err !== x_err)
      fail_line(x_tag, "rsp_err", 64'(host_rsp_err), 64'(x_err));
    else if (x_valid && host_rdata !== x_rdata)
      fail_line(x_tag, "rdata", 64'(host_rdata), 64'(x_rdata));
  endtask

  task automatic step(input logic rq, input logic we, input logic [19:0] a,
                      input logic [31:0] d, input string tag);
    logic        e_mreq;
    logic [24:0] e_maddr;
    logic        e_err;
    logic [31:0] e_rd;
    @(negedge clk);
    check_rsp();
    host_req = rq; host_we = we; host_addr = a; host_wdata = d;
    #1;
    e_mreq = 1'b0; e_maddr = '0; e_err = 1'b0; e_rd = 32'h0;
    if (rq) begin
      if (a[1:0] != 2'b00) begin
        e_err = 1'b1; e_rd = BAD;
      end else if (a == CTRL) begin
        if (we) begin
          m_en = d[30]; m_pg = d[5:0];
        end else begin
          e_rd = (32'(m_en) << 30) | 32'(m_pg);
        end
      end else if (a < 20'h80000) begin
        e_mreq = 1'b1; e_maddr = 25'(a);
      end else if (m_en) begin
        e_mreq = 1'b1; e_maddr = (25'(m_pg) << 19) | 25'(a & 20'h7FFFF);
      end else begin
        e_err = 1'b1; e_rd = BAD;
      end
      if (e_mreq && !we) e_rd = {7'h5A, e_maddr};
    end
    checks++;
    if (mem_req !== e_mreq)
      fail_line(tag, "mem_req", 64'(mem_req), 64'(e_mreq));
    else if (e_mreq && (mem_addr !== e_maddr || mem_we !== we || mem_wdata !== d))
      fail_line(tag, "mem_addr", 64'(mem_addr), 64'(e_maddr));
    x_valid = rq; x_err = e_err; x_rdata = e_rd; x_tag = tag;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    step(0, 0, 20'h0, 32'h0, "R1");
    step(1, 0, CTRL, 32'h0, "R1");
    step(1, 0, 20'h80000, 32'h0, "R1");
    // R2: fixed half
    step(1, 0, 20'h00000, 32'h0, "R2");
    step(1, 0, 20'h7FFFC, 32'h0, "R2");
    step(1, 0, 20'h03108, 32'h0, "R2");
    step(1, 1, 20'h12344, 32'hCAFE0001, "R2");
    step(0, 0, 20'h0, 32'h0, "R7");
    // R5: paged half disabled
    step(1, 0, 20'h80000, 32'h0, "R5");
    step(1, 1, 20'hFFFFC, 32'h11112222, "R5");
    // R4: control register
    step(1, 1, CTRL, 32'hFFFFFFFF, "R4");
    step(1, 0, CTRL, 32'h0, "R4");
    step(1, 1, CTRL, 32'h00000015, "R4");
    step(1, 0, CTRL, 32'h0, "R4");
    step(1, 1, CTRL, 32'h80000003, "R4");
    step(1, 0, CTRL, 32'h0, "R4");
    step(1, 0, 20'h80010, 32'h0, "R4");
    step(1, 1, CTRL, 32'h40000005, "R4");
    // R3: paged half enabled
    step(1, 0, 20'h80000, 32'h0, "R3");
    step(1, 0, 20'hFFFFC, 32'h0, "R3");
    step(1, 1, 20'hA0010, 32'h5555AAAA, "R3");
    step(1, 0, 20'h00040, 32'h0, "R3");
    // R8: update visible on the next cycle
    step(1, 1, CTRL, 32'h4000002A, "R8");
    step(1, 0, 20'h80004, 32'h0, "R8");
    step(1, 1, CTRL, 32'h0000002A, "R8");
    step(1, 0, 20'h80004, 32'h0, "R8");
    step(1, 1, CTRL, 32'h4000003F, "R8");
    step(1, 1, 20'hC0000, 32'h0BADF00D, "R8");
    // R6: misaligned
    step(1, 0, 20'h00001, 32'h0, "R6");
    step(1, 1, 20'h80002, 32'h0, "R6");
    step(1, 0, 20'h0310D, 32'h0, "R6");
    step(1, 1, 20'h0310E, 32'h40000001, "R6");
    step(1, 0, CTRL, 32'h0, "R6");
    // R7: idle gaps and back-to-back
    step(0, 0, 20'h0, 32'h0, "R7");
    step(1, 0, 20'h00100, 32'h0, "R7");
    step(0, 1, 20'h00104, 32'h0, "R7");
    step(1, 1, 20'h00108, 32'h77, "R7");
    step(1, 0, 20'h8010C, 32'h0, "R7");
    step(0, 0, 20'h0, 32'h0, "R7");
    step(0, 0, 20'h0, 32'h0, "R7");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule